// File: doc/BRIEF.md
# SPI EEPROM Command Engine

This block is the serial slave front end of a 512-byte EEPROM organised in 16-byte pages. A host talks to it over a four-wire serial link in clock mode 0 or mode 3, with an extra active-low pause input. All pins are first brought into the system clock domain and edge-detected there. Each frame starts with a one-byte opcode. The engine then collects an address and data, or streams read data and the status byte back to the host.

The status and protection rules live in a neighbouring block. That block supplies the status byte and two qualifiers: a write-allowed level and a busy level. It also receives one-cycle request pulses for latch set, latch clear and status write. Array writes are staged in a page buffer inside the engine. They reach the register array only when chip select rises exactly on a byte boundary.

Top module: `spi_eeprom_engine`

## Requirements
- R1: `spi_mosi` is sampled on rising `spi_sck`, most significant bit first. `spi_miso` changes only after a falling `spi_sck`, and read bytes also go out most significant bit first.
- R2: Opcode `0000_x110` gives one `req_wren` pulse and opcode `0000_x100` gives one `req_wrdi` pulse, where x is ignored. Each takes effect only when the frame holds exactly that one byte.
- R3: Opcode `0000_x101` shifts `status_in` out, and keeps sending it again for every further byte clocked.
- R4: Opcode `0000_a011` is followed by one address byte, where a is address bit 8. Array bytes are then streamed from that address, which increments after each byte and wraps from 0x1FF to 0x000.
- R5: Opcode `0000_a010` is followed by an address byte and one or more data bytes. The data land at addresses that step through the 16-byte page and wrap to the page start. `req_write` pulses with `req_addr` equal to the start address.
- R6: Opcode `0000_x001` followed by exactly one data byte pulses `req_wrsr`, and `req_byte` carries that data byte.
- R7: A request is issued only if `spi_csn` rises after the rising clock that completed a byte and before any further rising clock. Any other frame end discards the instruction.
- R8: Status writes and array writes commit only while `wr_enable` is 1 and `busy_in` is 0. The read, array-write and status-write opcodes are ignored for the whole frame when `busy_in` is 1 at opcode time. Latch set and clear are still accepted then.
- R9: An opcode outside the six above, including any with a nonzero upper nibble, kills the frame: `spi_miso_oe` stays 0 and no request follows until `spi_csn` goes high.
- R10: After reset, a falling `spi_csn` must be seen before any frame is decoded. A low level held through reset does not count.
- R11: `spi_miso_oe` is 0 while `spi_csn` is high, during a pause, in a killed frame, and in frames other than status read and array read.
- R12: A pause starts when `spi_holdn` is low while `spi_sck` is low, and ends when `spi_holdn` is high while `spi_sck` is low. Clock and data are ignored during a pause, and the frame resumes intact. If `spi_csn` rises during a pause, the frame is dropped without any request.
- R13: Each request is a one-cycle pulse. At most one request is active at a time. A request appears 3 system clocks after `spi_csn` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_holdn | input | 1 | Active-low pause |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| status_in | input | 8 | Status byte from protection block |
| busy_in | input | 1 | Internal write cycle in progress |
| wr_enable | input | 1 | Write permitted by protection block |
| req_wren | output | 1 | Write-latch set request pulse |
| req_wrdi | output | 1 | Write-latch clear request pulse |
| req_wrsr | output | 1 | Status write request pulse |
| req_write | output | 1 | Array page write committed pulse |
| req_addr | output | 9 | Start address of committed write |
| req_byte | output | 8 | Data byte of status write |

## Verification
Every serial pin passes two synchronizer flops and an edge register. As a result, `spi_miso` settles about three system clocks after a falling `spi_sck`, and the host model samples it six clocks later, just before the next rising edge. A request pulse comes exactly three clocks after `spi_csn` rises. The monitor pops one queued expectation per pulse cycle while the host waits ten clocks. A stretched or extra pulse therefore shows up as a mismatch, and the checker pins down the three-cycle offset. A write or discard is then confirmed with a later read of the same addresses.

// File: rtl/spee_pkg.sv
package spee_pkg;

    localparam int ARRAY_ADDR_W = 9;
    localparam int BYTE_W       = 8;
    localparam int PAGE_OFF_W   = 4;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_WRDI,
        CMD_RDSR,
        CMD_WRSR,
        CMD_READ,
        CMD_WRITE
    } cmd_e;

    typedef struct packed {
        logic wren;
        logic wrdi;
        logic wrsr;
        logic write;
    } req_t;

    function automatic cmd_e decode_op(input logic [7:0] op);
        cmd_e c;
        c = CMD_NONE;
        if (op[7:4] == 4'h0) begin
            case (op[2:0])
                3'b110:  c = CMD_WREN;
                3'b100:  c = CMD_WRDI;
                3'b101:  c = CMD_RDSR;
                3'b001:  c = CMD_WRSR;
                3'b011:  c = CMD_READ;
                3'b010:  c = CMD_WRITE;
                default: c = CMD_NONE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/spee_sync.sv
module spee_sync #(
    parameter int           N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] s1, s2, s3;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                s1[i] <= RST_VAL[i];
                s2[i] <= RST_VAL[i];
                s3[i] <= RST_VAL[i];
            end else begin
                s1[i] <= d[i];
                s2[i] <= s1[i];
                s3[i] <= s2[i];
            end
        end
        assign rise[i] = s2[i] & ~s3[i];
        assign fall[i] = ~s2[i] & s3[i];
    end

    assign q = s2;
endmodule

// File: rtl/spee_array.sv
module spee_array #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     stage_clr,
    input  logic                     stage_we,
    input  logic [PAGE_W-1:0]        stage_off,
    input  logic [DATA_W-1:0]        stage_data,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] pbuf [PAGE];
    logic [PAGE-1:0]   pmask;

    always_ff @(posedge clk) begin
        if (rst) begin
            pmask <= '0;
            for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
        end else if (stage_clr) begin
            pmask <= '0;
        end else if (stage_we) begin
            pbuf[stage_off]  <= stage_data;
            pmask[stage_off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++) begin
                if (pmask[i]) mem[{commit_page, PAGE_W'(i)}] <= pbuf[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spee_frame.sv
module spee_frame
    import spee_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sck_lvl,
    input  logic                     sck_rise,
    input  logic                     sck_fall,
    input  logic                     cs_rise,
    input  logic                     cs_fall,
    input  logic                     mosi_lvl,
    input  logic                     holdn_lvl,
    input  logic [DATA_W-1:0]        status_in,
    input  logic                     busy_in,
    input  logic                     wr_enable,
    input  logic [DATA_W-1:0]        rd_data,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     stage_clr,
    output logic                     stage_we,
    output logic [PAGE_W-1:0]        stage_off,
    output logic [DATA_W-1:0]        stage_data,
    output logic                     commit,
    output logic [ADDR_W-PAGE_W-1:0] commit_page,
    output logic                     miso,
    output logic                     miso_oe,
    output req_t                     req,
    output logic [ADDR_W-1:0]        req_addr,
    output logic [DATA_W-1:0]        req_byte
);
    localparam int                BCNT_W   = $clog2(DATA_W);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(DATA_W - 1);

    logic              armed, dead, hold_q, boundary, addr_hi;
    logic [BCNT_W-1:0] bit_cnt;
    logic [1:0]        byte_cnt;
    logic [DATA_W-1:0] sr, out_sr, wr_byte;
    logic [ADDR_W-1:0] addr, start_addr;
    logic              miso_q;
    cmd_e              cmd, op_cmd;

    logic              active, byte_done, commit_ok, wr_gate;
    logic [DATA_W-1:0] new_byte;
    req_t              nreq;

    assign active    = armed & ~dead & ~hold_q;
    assign byte_done = sck_rise & active & (bit_cnt == LAST_BIT);
    assign new_byte  = {sr[DATA_W-2:0], mosi_lvl};
    assign op_cmd    = decode_op(new_byte);
    assign rd_addr   = (byte_cnt == 2'd1) ? ADDR_W'({addr_hi, new_byte}) : addr;

    assign stage_clr  = cs_fall;
    assign stage_we   = byte_done & (cmd == CMD_WRITE) & (byte_cnt >= 2'd2);
    assign stage_off  = addr[PAGE_W-1:0];
    assign stage_data = new_byte;

    assign commit_ok = cs_rise & armed & ~dead & ~hold_q & boundary;
    assign wr_gate   = wr_enable & ~busy_in;

    always_comb begin
        nreq       = '0;
        nreq.wren  = commit_ok && cmd == CMD_WREN  && byte_cnt == 2'd1;
        nreq.wrdi  = commit_ok && cmd == CMD_WRDI  && byte_cnt == 2'd1;
        nreq.wrsr  = commit_ok && cmd == CMD_WRSR  && byte_cnt == 2'd2 && wr_gate;
        nreq.write = commit_ok && cmd == CMD_WRITE && byte_cnt == 2'd3 && wr_gate;
    end

    assign commit      = nreq.write;
    assign commit_page = start_addr[ADDR_W-1:PAGE_W];
    assign miso        = miso_q;
    assign miso_oe     = active & ((cmd == CMD_RDSR) | (cmd == CMD_READ));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            dead       <= 1'b0;
            hold_q     <= 1'b0;
            boundary   <= 1'b0;
            addr_hi    <= 1'b0;
            bit_cnt    <= '0;
            byte_cnt   <= '0;
            sr         <= '0;
            out_sr     <= '0;
            wr_byte    <= '0;
            addr       <= '0;
            start_addr <= '0;
            miso_q     <= 1'b0;
            cmd        <= CMD_NONE;
            req        <= '0;
            req_addr   <= '0;
            req_byte   <= '0;
        end else begin
            req <= nreq;
            if (nreq.write) req_addr <= start_addr;
            if (nreq.wrsr)  req_byte <= wr_byte;

            if (cs_rise) begin
                armed  <= 1'b0;
                dead   <= 1'b0;
                hold_q <= 1'b0;
                cmd    <= CMD_NONE;
            end else if (cs_fall) begin
                armed    <= 1'b1;
                dead     <= 1'b0;
                hold_q   <= 1'b0;
                boundary <= 1'b0;
                bit_cnt  <= '0;
                byte_cnt <= '0;
                out_sr   <= '0;
                miso_q   <= 1'b0;
                cmd      <= CMD_NONE;
            end else begin
                if (armed && !hold_q && !holdn_lvl && !sck_lvl)
                    hold_q <= 1'b1;
                else if (hold_q && holdn_lvl && !sck_lvl)
                    hold_q <= 1'b0;

                if (sck_rise && active) begin
                    sr       <= new_byte;
                    bit_cnt  <= bit_cnt + 1'b1;
                    boundary <= (bit_cnt == LAST_BIT);
                end

                if (byte_done) begin
                    if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
                    case (byte_cnt)
                        2'd0: begin
                            cmd     <= op_cmd;
                            addr_hi <= new_byte[3];
                            if (op_cmd == CMD_NONE ||
                                (busy_in && (op_cmd == CMD_READ || op_cmd == CMD_WRITE ||
                                             op_cmd == CMD_WRSR)))
                                dead <= 1'b1;
                            if (op_cmd == CMD_RDSR) out_sr <= status_in;
                        end
                        2'd1: begin
                            case (cmd)
                                CMD_READ: begin
                                    out_sr <= rd_data;
                                    addr   <= rd_addr + 1'b1;
                                end
                                CMD_WRITE: begin
                                    addr       <= rd_addr;
                                    start_addr <= rd_addr;
                                end
                                CMD_WRSR: wr_byte <= new_byte;
                                CMD_RDSR: out_sr  <= status_in;
                                default: ;
                            endcase
                        end
                        default: begin
                            case (cmd)
                                CMD_READ: begin
                                    out_sr <= rd_data;
                                    addr   <= addr + 1'b1;
                                end
                                CMD_WRITE: addr <= {addr[ADDR_W-1:PAGE_W],
                                                    addr[PAGE_W-1:0] + 1'b1};
                                CMD_RDSR:  out_sr <= status_in;
                                default: ;
                            endcase
                        end
                    endcase
                end

                if (sck_fall && active) begin
                    miso_q <= out_sr[DATA_W-1];
                    out_sr <= {out_sr[DATA_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
    import spee_pkg::*;
#(
    parameter int ADDR_W = ARRAY_ADDR_W,
    parameter int PAGE_W = PAGE_OFF_W,
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    input  logic              spi_holdn,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [DATA_W-1:0] status_in,
    input  logic              busy_in,
    input  logic              wr_enable,
    output logic              req_wren,
    output logic              req_wrdi,
    output logic              req_wrsr,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_byte
);
    localparam int PIN_N    = 4;
    localparam int PG_NUM_W = ADDR_W - PAGE_W;

    logic [PIN_N-1:0] pin_q, pin_rise, pin_fall;
    logic [ADDR_W-1:0]   rd_addr;
    logic [DATA_W-1:0]   rd_data, stage_data;
    logic                stage_clr, stage_we, commit;
    logic [PAGE_W-1:0]   stage_off;
    logic [PG_NUM_W-1:0] commit_page;
    req_t                req;

    spee_sync #(.N(PIN_N), .RST_VAL(4'b1000)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    ({spi_holdn, spi_mosi, spi_csn, spi_sck}),
        .q    (pin_q),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    spee_frame #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .sck_lvl     (pin_q[0]),
        .sck_rise    (pin_rise[0]),
        .sck_fall    (pin_fall[0]),
        .cs_rise     (pin_rise[1]),
        .cs_fall     (pin_fall[1]),
        .mosi_lvl    (pin_q[2]),
        .holdn_lvl   (pin_q[3]),
        .status_in   (status_in),
        .busy_in     (busy_in),
        .wr_enable   (wr_enable),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .stage_clr   (stage_clr),
        .stage_we    (stage_we),
        .stage_off   (stage_off),
        .stage_data  (stage_data),
        .commit      (commit),
        .commit_page (commit_page),
        .miso        (spi_miso),
        .miso_oe     (spi_miso_oe),
        .req         (req),
        .req_addr    (req_addr),
        .req_byte    (req_byte)
    );

    spee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_array (
        .clk         (clk),
        .rst         (rst),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .stage_clr   (stage_clr),
        .stage_we    (stage_we),
        .stage_off   (stage_off),
        .stage_data  (stage_data),
        .commit      (commit),
        .commit_page (commit_page)
    );

    assign req_wren  = req.wren;
    assign req_wrdi  = req.wrdi;
    assign req_wrsr  = req.wrsr;
    assign req_write = req.write;
endmodule

// File: rtl/spee_checks.sv
module spee_checks (
    input logic clk,
    input logic rst,
    input logic spi_csn,
    input logic spi_miso_oe,
    input logic busy_in,
    input logic wr_enable,
    input logic req_wren,
    input logic req_wrdi,
    input logic req_wrsr,
    input logic req_write
);
    logic any_req;
    assign any_req = req_wren | req_wrdi | req_wrsr | req_write;

    assert_one_req_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_wren, req_wrdi, req_wrsr, req_write}));

    assert_req_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        any_req |=> !any_req);

    assert_req_after_cs_R7: assert property (@(posedge clk) disable iff (rst)
        any_req |-> $past(spi_csn, 3));

    assert_write_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (req_write || req_wrsr) |-> $past(wr_enable && !busy_in));

    assert_oe_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3))
            |-> !spi_miso_oe);
endmodule

bind spi_eeprom_engine spee_checks u_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_csn     (spi_csn),
    .spi_miso_oe (spi_miso_oe),
    .busy_in     (busy_in),
    .wr_enable   (wr_enable),
    .req_wren    (req_wren),
    .req_wrdi    (req_wrdi),
    .req_wrsr    (req_wrsr),
    .req_write   (req_write)
);

// File: tb/spi_eeprom_engine_test.sv
module spi_eeprom_engine_test;
    localparam int H       = 6;
    localparam int K_RD    = 0;
    localparam int K_WREN  = 1;
    localparam int K_WRDI  = 2;
    localparam int K_WRSR  = 3;
    localparam int K_WRITE = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, sck, csn, mosi, holdn, busy_in, wr_enable;
    logic [7:0] status_in;
    logic       miso, miso_oe, req_wren, req_wrdi, req_wrsr, req_write;
    logic [8:0] req_addr;
    logic [7:0] req_byte;

    spi_eeprom_engine uut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
        .spi_holdn(holdn), .spi_miso(miso), .spi_miso_oe(miso_oe),
        .status_in(status_in), .busy_in(busy_in), .wr_enable(wr_enable),
        .req_wren(req_wren), .req_wrdi(req_wrdi), .req_wrsr(req_wrsr),
        .req_write(req_write), .req_addr(req_addr), .req_byte(req_byte)
    );

    typedef struct {
        int    kind;
        int    val;
        string tag;
    } item_t;

    item_t expq[$];
    int    n_cmp = 0;
    int    n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int kind, input int val, input string tag);
        item_t it;
        it.kind = kind; it.val = val; it.tag = tag;
        expq.push_back(it);
    endtask

    task automatic take(input int kind, input int val);
        item_t it;
        if (expq.size() == 0) begin
            chk("R13 unexpected event", kind * 1024 + val, -1);
        end else begin
            it = expq.pop_front();
            chk(it.tag, kind * 1024 + val, it.kind * 1024 + it.val);
        end
    endtask

    // monitor: one pop per request pulse cycle (R13)
    always @(negedge clk) begin
        if (!rst) begin
            if (req_wren)  take(K_WREN, 0);
            if (req_wrdi)  take(K_WRDI, 0);
            if (req_wrsr)  take(K_WRSR, int'(req_byte));
            if (req_write) take(K_WRITE, int'(req_addr));
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // host model: n bytes of b (first byte in the top bits)
    task automatic frame(input logic [47:0] b, input int n, input int rd_from,
                         input int extra, input int hold_at, input bit abort,
                         input int oe_exp, input string tag);
        logic [7:0] r;
        int total;
        r = 8'h00;
        total = n * 8;
        @(negedge clk);
        csn = 1'b0;
        wait_clk(4);
        for (int g = 0; g <= total; g++) begin
            if (g == hold_at) begin
                holdn = 1'b0;
                wait_clk(6);
                chk("R11 oe in pause", int'(miso_oe), 0);
                for (int k = 0; k < 2; k++) begin
                    mosi = 1'b1; sck = 1'b1; wait_clk(H);
                    sck = 1'b0; wait_clk(H);
                end
                if (abort) begin
                    csn = 1'b1;
                    wait_clk(6);
                    holdn = 1'b1;
                    wait_clk(8);
                    return;
                end
                holdn = 1'b1;
                wait_clk(6);
            end
            if (g < total) begin
                mosi = b[47-g];
                wait_clk(H);
                r = {r[6:0], miso};
                sck = 1'b1;
                wait_clk(H);
                sck = 1'b0;
                if ((g % 8) == 7 && (g / 8) >= rd_from) take(K_RD, int'(r));
            end
        end
        for (int e = 0; e < extra; e++) begin
            mosi = 1'b0; wait_clk(H); sck = 1'b1; wait_clk(H); sck = 1'b0;
        end
        wait_clk(H);
        if (oe_exp >= 0) chk(tag, int'(miso_oe), oe_exp);
        csn = 1'b1;
        wait_clk(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; sck = 1'b0; csn = 1'b0; mosi = 1'b0; holdn = 1'b1;
        busy_in = 1'b0; wr_enable = 1'b1; status_in = 8'hA5;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        chk("R11 reset oe", int'(miso_oe), 0);

        // R10: chip select low since reset, no falling edge -> ignored
        for (int g = 0; g < 8; g++) begin
            mosi = (8'h06 >> (7 - g)) & 1'b1;
            wait_clk(H); sck = 1'b1; wait_clk(H); sck = 1'b0;
        end
        wait_clk(H); csn = 1'b1; wait_clk(10);
        chk("R10 no request before first fall", expq.size(), 0);

        // R2 latch set / clear, don't-care bit
        push(K_WREN, 0, "R2 wren");
        frame({8'h06, 40'h0}, 1, 99, 0, -1, 0, 0, "R11 oe in wren");
        push(K_WRDI, 0, "R2 wrdi");
        frame({8'h04, 40'h0}, 1, 99, 0, -1, 0, -1, "");
        push(K_WREN, 0, "R2 wren x bit");
        frame({8'h0E, 40'h0}, 1, 99, 0, -1, 0, -1, "");

        // R3 / R1 status streaming
        push(K_RD, 8'hA5, "R1 R3 status byte0");
        push(K_RD, 8'hA5, "R3 status byte1");
        frame({8'h05, 40'h0}, 3, 1, 0, -1, 0, 1, "R11 oe in status read");

        // R5 page write with wrap (A8=1), R4 read wrap
        push(K_WRITE, 9'h1FE, "R5 write start");
        frame({8'h0A, 8'hFE, 8'h11, 8'h22, 8'h33, 8'h00}, 5, 99, 0, -1, 0, -1, "");
        push(K_RD, 8'h11, "R4 read 1FE");
        push(K_RD, 8'h22, "R4 read 1FF");
        push(K_RD, 8'h00, "R4 read wrap 000");
        push(K_RD, 8'h00, "R4 read 001");
        frame({8'h0B, 8'hFE, 32'h0}, 6, 2, 0, -1, 0, -1, "");
        push(K_RD, 8'h33, "R5 page wrap 1F0");
        frame({8'h0B, 8'hF0, 32'h0}, 3, 2, 0, -1, 0, -1, "");

        // R4 A8=0 lower half
        push(K_WRITE, 9'h010, "R5 write 010");
        frame({8'h02, 8'h10, 8'hAA, 24'h0}, 3, 99, 0, -1, 0, -1, "");
        push(K_RD, 8'h00, "R4 read 00F");
        push(K_RD, 8'hAA, "R4 read 010");
        frame({8'h03, 8'h0F, 32'h0}, 4, 2, 0, -1, 0, -1, "");

        // R7 chip select off a byte boundary -> discarded
        frame({8'h02, 8'h20, 8'h55, 24'h0}, 3, 99, 3, -1, 0, -1, "");
        frame({8'h06, 40'h0}, 1, 99, 2, -1, 0, -1, "");
        push(K_RD, 8'h00, "R7 read 020 unchanged");
        frame({8'h03, 8'h20, 32'h0}, 3, 2, 0, -1, 0, -1, "");

        // R8 gating
        wr_enable = 1'b0;
        frame({8'h02, 8'h30, 8'h77, 24'h0}, 3, 99, 0, -1, 0, -1, "");
        frame({8'h01, 8'h0C, 32'h0}, 2, 99, 0, -1, 0, -1, "");
        wr_enable = 1'b1;
        busy_in = 1'b1;
        frame({8'h02, 8'h30, 8'h77, 24'h0}, 3, 99, 0, -1, 0, -1, "");
        frame({8'h03, 8'h30, 32'h0}, 3, 99, 0, -1, 0, 0, "R8 read ignored when busy");
        push(K_WREN, 0, "R8 wren accepted when busy");
        frame({8'h06, 40'h0}, 1, 99, 0, -1, 0, -1, "");
        busy_in = 1'b0;
        push(K_RD, 8'h00, "R8 read 030 unchanged");
        frame({8'h03, 8'h30, 32'h0}, 3, 2, 0, -1, 0, -1, "");

        // R6 status write
        push(K_WRSR, 8'h0C, "R6 status write data");
        frame({8'h01, 8'h0C, 32'h0}, 2, 99, 0, -1, 0, -1, "");

        // R9 invalid opcodes
        frame({8'h85, 40'h0}, 1, 99, 0, -1, 0, 0, "R9 oe after bad opcode");
        frame({8'h07, 8'h06, 32'h0}, 2, 99, 0, -1, 0, -1, "");
        frame({8'h00, 40'h0}, 1, 99, 0, -1, 0, 0, "R9 opcode 00 killed");

        // R12 pause during write, frame resumes intact
        push(K_WRITE, 9'h040, "R12 write across pause");
        frame({8'h02, 8'h40, 8'h9A, 24'h0}, 3, 99, 0, 11, 0, -1, "");
        push(K_RD, 8'h9A, "R12 read 040");
        frame({8'h03, 8'h40, 32'h0}, 3, 2, 0, -1, 0, -1, "");
        // R12 pause during status output
        push(K_RD, 8'hA5, "R12 status across pause");
        frame({8'h05, 40'h0}, 2, 1, 0, 12, 0, -1, "");
        // R12 chip select rises in pause at a byte boundary -> dropped
        frame({8'h02, 8'h50, 8'h66, 24'h0}, 3, 99, 0, 24, 1, -1, "");
        push(K_RD, 8'h00, "R12 read 050 unchanged");
        frame({8'h03, 8'h50, 32'h0}, 3, 2, 0, -1, 0, -1, "");

        wait_clk(20);
        chk("R13 all expected events seen", expq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule